// File: doc/BRIEF.md
# Shared Open-Drain Fault Line Controller

This block owns one active-low fault wire that several devices share through open-drain pull-downs. When the local power sequencer reports a fault, the block pulls the wire low. How long it holds the wire depends on the cause. A supply undervoltage keeps the wire low for as long as the supply stays below threshold. Every other cause gives a fixed one-shot pulse. When the drive ends, the block tells the sequencer with a single-cycle flag.

The block also watches the wire for pulls made by other devices or external logic. It passes the pin through a synchronizer. A low must last a set number of consecutive samples before the block reports an external fault, so short glitches are discarded. A low caused by the block's own drive is never reported. This blanking continues for one filter period after the drive is released, which gives the shared wire time to recover.

A fault in any device on the wire therefore reaches every other device, and each of them shuts its outputs down.

Top module: `fault_line_ctrl`

## Requirements
- R1: After reset, `pull_en`, `ext_fault` and `hold_done` are all 0.
- R2: A fault request with `flt_is_uv` = 0, sampled while the block is not driving, raises `pull_en` from the next cycle for exactly HOLD_CYCLES cycles.
- R3: A fault request with `flt_is_uv` = 1 raises `pull_en` from the next cycle. `pull_en` stays high until the first clock edge that samples `uv_low` = 0, and falls at that edge.
- R4: `hold_done` is 1 for exactly one cycle, the first cycle after `pull_en` falls. It is never 1 at any other time.
- R5: When the wire goes low outside blanking and stays low, `ext_fault` rises SYNC_STAGES + FILT_CYCLES clock edges later.
- R6: A low shorter than FILT_CYCLES consecutive synchronized samples never raises `ext_fault`.
- R7: Once the wire returns high, `ext_fault` falls SYNC_STAGES + 1 clock edges later.
- R8: While `pull_en` is high, and for FILT_CYCLES cycles after it falls, wire lows are not counted and `ext_fault` stays 0.
- R9: A request with `flt_is_uv` = 0 that arrives during an active drive is ignored. The pulse is not restarted or extended.
- R10: A request with `flt_is_uv` = 1 that arrives during a one-shot pulse turns the drive into an undervoltage hold, which then ends as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw level sampled from the shared fault wire (1 = released) |
| flt_req | input | 1 | Single-cycle internal fault request from the sequencer |
| flt_is_uv | input | 1 | Cause of the request: 1 = supply undervoltage, 0 = any other cause |
| uv_low | input | 1 | Live undervoltage state: 1 = the monitored supply is below threshold |
| pull_en | output | 1 | Enable for the open-drain pull-down on the wire |
| ext_fault | output | 1 | Qualified external pull detected on the wire |
| hold_done | output | 1 | Single-cycle pulse: the block has released the wire |

## Verification
The hardest case to reach is an external pull that starts while the block is still driving the wire and continues after the block releases it. Two things must happen in that case. No fault may be reported during the blanking period. After blanking ends, the fault must be reported at exactly the right cycle, with the low-run count starting from zero.

The bench produces this case from the ports. It models the wire as the AND of the block's own release and an external pull. It raises the external pull in the middle of a one-shot pulse and holds it for well past the release. A behavioural reference model predicts the exact cycle at which `ext_fault` rises.

// File: rtl/fault_line_pkg.sv
package fault_line_pkg;

    typedef enum logic [1:0] {
        DRV_IDLE  = 2'd0,
        DRV_PULSE = 2'd1,
        DRV_UVHLD = 2'd2
    } drv_state_e;

endpackage

// File: rtl/fault_line_sync.sv
module fault_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], async_i};
    end

    // Idle level of the wire is released (high)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{chain: '1};
        else        r_q <= r_d;
    end

    assign sync_o = r_q.chain[STAGES-1];
endmodule

// File: rtl/fault_line_drive.sv
module fault_line_drive
    import fault_line_pkg::*;
#(
    parameter int HOLD_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flt_req,
    input  logic flt_is_uv,
    input  logic uv_low,
    output logic pull_en,
    output logic hold_done
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        drv_state_e    state;
        logic [CW-1:0] cnt;
        logic          pull;
        logic          done;
    } drv_regs_t;

    drv_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            DRV_IDLE: begin
                if (flt_req) begin
                    if (flt_is_uv) begin
                        r_d.state = DRV_UVHLD;
                    end else begin
                        r_d.state = DRV_PULSE;
                        r_d.cnt   = LAST;
                    end
                end
            end
            DRV_PULSE: begin
                if (flt_req && flt_is_uv) begin
                    r_d.state = DRV_UVHLD;
                end else if (r_q.cnt == '0) begin
                    r_d.state = DRV_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            DRV_UVHLD: begin
                if (!uv_low) begin
                    r_d.state = DRV_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = DRV_IDLE;
        endcase
        r_d.pull = (r_d.state != DRV_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: DRV_IDLE, cnt: '0, pull: 1'b0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign pull_en   = r_q.pull;
    assign hold_done = r_q.done;

    AST_IDLE_REQ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_req && !pull_en) |=> pull_en); // R2

    AST_UV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DRV_UVHLD && uv_low) |=> pull_en); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |=> !hold_done); // R4

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> (!pull_en && $past(pull_en))); // R4

    AST_PULSE_NOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DRV_PULSE && flt_req && !flt_is_uv && r_q.cnt != '0)
        |=> (r_q.cnt == $past(r_q.cnt) - 1'b1)); // R9

    AST_UV_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DRV_PULSE && flt_req && flt_is_uv) |=> (r_q.state == DRV_UVHLD)); // R10
endmodule

// File: rtl/fault_line_filter.sv
module fault_line_filter #(
    parameter int FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic pull_en_i,
    output logic ext_fault
);
    localparam int RW = $clog2(FILT_CYCLES + 1);
    localparam logic [RW-1:0] FMAX = RW'(FILT_CYCLES);
    localparam logic [RW-1:0] FTHR = RW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic [RW-1:0] blank;
        logic          ext;
    } filt_regs_t;

    filt_regs_t r_d, r_q;
    logic       blanked;

    always_comb begin
        r_d     = r_q;
        blanked = pull_en_i || (r_q.blank != '0);
        if (pull_en_i)              r_d.blank = FMAX;
        else if (r_q.blank != '0)   r_d.blank = r_q.blank - 1'b1;
        else                        r_d.blank = '0;

        if (blanked || line_s) begin
            r_d.run = '0;
            r_d.ext = 1'b0;
        end else begin
            r_d.run = (r_q.run == FMAX) ? r_q.run : r_q.run + 1'b1;
            r_d.ext = (r_q.run >= FTHR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{run: '0, blank: '0, ext: 1'b0};
        else        r_q <= r_d;
    end

    assign ext_fault = r_q.ext;

    AST_NO_EXT_OWN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pull_en_i |=> !ext_fault); // R8

    AST_EXT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_fault) |-> !$past(line_s)); // R5

    AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> !ext_fault); // R7
endmodule

// File: rtl/fault_line_ctrl.sv
module fault_line_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 20,
    parameter int FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic flt_req,
    input  logic flt_is_uv,
    input  logic uv_low,
    output logic pull_en,
    output logic ext_fault,
    output logic hold_done
);
    logic line_s;
    logic pull_w;

    fault_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_in),
        .sync_o  (line_s)
    );

    fault_line_drive #(.HOLD_CYCLES(HOLD_CYCLES)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .flt_req   (flt_req),
        .flt_is_uv (flt_is_uv),
        .uv_low    (uv_low),
        .pull_en   (pull_w),
        .hold_done (hold_done)
    );

    fault_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .pull_en_i (pull_w),
        .ext_fault (ext_fault)
    );

    assign pull_en = pull_w;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!pull_en && !hold_done && !ext_fault)); // R1

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> !pull_en); // R4
endmodule

// File: tb/fault_line_ctrl_bench.sv
`timescale 1ns/1ps
module fault_line_ctrl_bench;
    localparam int SYNC = 2;
    localparam int HOLD = 20;
    localparam int FILT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flt_req = 1'b0, flt_is_uv = 1'b0, uv_low = 1'b0, ext_pull = 1'b0;
    logic pull_en, ext_fault, hold_done;
    wire  line_in = ~(pull_en | ext_pull);

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    fault_line_ctrl #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .FILT_CYCLES(FILT)) u_fault_line_ctrl (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .flt_req(flt_req),
        .flt_is_uv(flt_is_uv), .uv_low(uv_low), .pull_en(pull_en),
        .ext_fault(ext_fault), .hold_done(hold_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Behavioural reference model
    int m_state = 0, m_cnt = 0, m_run = 0, m_blank = 0;
    bit m_pull = 0, m_done = 0, m_ext = 0;
    bit m_sync[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_run = 0; m_blank = 0;
            m_pull = 0; m_done = 0; m_ext = 0;
            m_sync = '{1'b1, 1'b1};
        end else begin
            bit wire_lvl, seen, blk;
            wire_lvl = !(m_pull || ext_pull);
            seen = m_sync[SYNC-1];
            m_sync.push_front(wire_lvl);
            void'(m_sync.pop_back());
            blk = m_pull || (m_blank > 0);
            if (blk || seen) begin m_ext = 0; m_run = 0; end
            else begin m_ext = (m_run >= FILT - 1); if (m_run < FILT) m_run++; end
            if (m_pull) m_blank = FILT; else if (m_blank > 0) m_blank--;
            m_done = 0;
            if (m_state == 0) begin
                if (flt_req) begin
                    if (flt_is_uv) m_state = 2; else begin m_state = 1; m_cnt = HOLD - 1; end
                end
            end else if (m_state == 1) begin
                if (flt_req && flt_is_uv) m_state = 2;
                else if (m_cnt == 0) begin m_state = 0; m_done = 1; end
                else m_cnt--;
            end else begin
                if (!uv_low) begin m_state = 0; m_done = 1; end
            end
            m_pull = (m_state != 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 R3 R10 pull_en vs model", pull_en, m_pull);
            check("R5 R6 R7 R8 ext_fault vs model", ext_fault, m_ext);
            check("R4 hold_done vs model", hold_done, m_done);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input bit uv);
        flt_req = 1; flt_is_uv = uv;
        step(1);
        flt_req = 0; flt_is_uv = 0;
    endtask

    initial begin
        int k;
        bit seen;
        step(3);
        check("R1 pull_en reset", pull_en, 0);
        check("R1 ext_fault reset", ext_fault, 0);
        check("R1 hold_done reset", hold_done, 0);
        rst_n = 1;
        step(3);

        // R2: one-shot width
        request(0);
        k = 0;
        while (pull_en && k < 1000) begin k++; step(1); end
        check("R2 pulse width", k, HOLD);
        check("R4 done after pulse", hold_done, 1);
        step(1);
        check("R4 done single cycle", hold_done, 0);
        step(FILT + 4);

        // R3: undervoltage hold
        uv_low = 1;
        request(1);
        step(30);
        check("R3 held during undervoltage", pull_en, 1);
        uv_low = 0;
        step(1);
        check("R3 released when uv clears", pull_en, 0);
        check("R4 done after uv release", hold_done, 1);
        step(FILT + 4);

        // R5 / R7: external long pull
        ext_pull = 1;
        k = 0;
        while (!ext_fault && k < 100) begin step(1); k++; end
        check("R5 ext latency", k, SYNC + FILT);
        step(5);
        ext_pull = 0;
        k = 0;
        while (ext_fault && k < 100) begin step(1); k++; end
        check("R7 clear latency", k, SYNC + 1);
        step(4);

        // R6: short glitch
        ext_pull = 1;
        step(FILT - 1);
        ext_pull = 0;
        seen = 0;
        for (int i = 0; i < 12; i++) begin step(1); if (ext_fault) seen = 1; end
        check("R6 short low rejected", seen, 0);

        // R8: own drive and external overlap
        request(0);
        step(5);
        ext_pull = 1;
        seen = 0;
        while (pull_en) begin if (ext_fault) seen = 1; step(1); end
        for (int i = 0; i < FILT; i++) begin if (ext_fault) seen = 1; step(1); end
        check("R8 no report while blanked", seen, 0);
        step(SYNC + FILT + 2);
        check("R8 reported after blanking", ext_fault, 1);
        ext_pull = 0;
        step(FILT + 6);

        // R9: non-uv retrigger ignored
        request(0);
        step(5);
        request(0);
        k = 6;
        while (pull_en && k < 1000) begin k++; step(1); end
        check("R9 no retrigger width", k, HOLD);
        step(FILT + 4);

        // R10: uv request during pulse
        uv_low = 1;
        request(0);
        step(3);
        request(1);
        step(HOLD + 5);
        check("R10 promoted to hold", pull_en, 1);
        uv_low = 0;
        step(1);
        check("R10 release after uv", pull_en, 0);
        step(FILT + 4);

        finish_run();
    end
endmodule